// File: doc/BRIEF.md
# Cascadable Line-Scan Sequencer

This block sequences the digital readout of one die in a row of linear image sensors that are chained end to end. It samples its inputs and advances its state on the falling edge of the pixel clock. A scan starts from one of two inputs: the shared line-start pulse, used by the head die, or the chain-start input, which is wired to the end-of-scan output of the die in front. A strap selects which of the two this die obeys. The same strap sets how long the die waits before its first pixel pair. The head die waits 55 clocks, which carry 110 dummy pixels. A chained die waits 10 clocks, so that its first pair lands on the clock right after the last pair of the die in front.

The die presents two pixels per clock. Pixel values are not modelled: the output carries the index of the lower pixel of each pair, and the upper one is that index plus one. A second strap selects full resolution (688 pixels over 344 clocks) or half resolution (344 binned pixels over 172 clocks). The clock rate is the same in both modes. The end-of-scan pulse is issued ten clocks before the die's final pair, which is twenty pixels early. This lets the next die finish its own 10-clock wait exactly as this die runs out of pixels.

The sequencer has three states. `ST_IDLE` waits for a start. `ST_PRESCAN` counts the wait. `ST_READ` streams the pairs. The transition start (`ST_IDLE` to `ST_PRESCAN`) fires on an edge that samples the selected start input high. The transition delay-done (`ST_PRESCAN` to `ST_READ`) fires on the edge that ends the wait. The transition line-done (`ST_READ` to `ST_IDLE`) fires on the edge that ends the final pair.

Top module: `scan_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pix_valid`, `pix_idx`, `eol_out`, `amp_on` and `start_err` are all 0. The sequencer is in `ST_IDLE`.
- R2: With `head_sel`=1, a falling clock edge that samples `line_start` high begins a scan. For the next 55 clocks `pix_valid` is 0. The first pair is presented on clock 56, counting the clock that follows the sampling edge as clock 1.
- R3: With `fine_res`=1 at scan start, the scan presents 344 consecutive pairs, one per clock. `pix_idx` steps through 1, 3, 5, … 687.
- R4: With `fine_res`=0 at scan start, the scan presents 172 pairs. `pix_idx` steps through 1, 3, … 343.
- R5: `eol_out` is high for exactly one clock per scan: the clock that presents pixel 668 in full resolution, or pixel 324 in half resolution. That is 10 clocks before the final pair, and clock 389 or clock 217 for the head die.
- R6: `amp_on` is high exactly on the clocks on which `pix_valid` is high.
- R7: With `head_sel`=0, `line_start` has no effect. A falling edge that samples `chain_in` high begins a scan whose first pair is presented on clock 11, so the latency from the sampling edge to the first pair is 10 clocks.
- R8: A start sampled while a scan is in `ST_PRESCAN` or `ST_READ` is ignored. The running scan continues unchanged.
- R9: `fine_res` is captured at scan start. Changing it during a scan does not alter that scan's length or its end-of-scan position.
- R10: If the selected start input is sampled high on two consecutive falling edges, `start_err` is high for exactly the one clock after the second edge. A one-edge start never raises it.
- R11: After the final pair the sequencer returns to `ST_IDLE`. All outputs go to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the falling edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Shared line-start pulse, obeyed only when `head_sel`=1 |
| chain_in | input | 1 | Start from the previous die's end-of-scan, obeyed only when `head_sel`=0 |
| head_sel | input | 1 | Strap: 1 = head die (55-clock wait), 0 = chained die (10-clock wait) |
| fine_res | input | 1 | Strap: 1 = 344 pairs per scan, 0 = 172 binned pairs |
| pix_idx | output | 10 | Lower pixel index of the current pair, 0 when not valid |
| pix_valid | output | 1 | A pixel pair is being presented this clock |
| eol_out | output | 1 | One-clock end-of-scan pulse for the next die |
| amp_on | output | 1 | Output amplifier enable |
| start_err | output | 1 | One-clock flag for a start held across two edges |

## Verification
On every clock, the assertions check the following:
- a new readout opens at pixel 1;
- consecutive pairs step by two;
- a readout closes on pixel 687 or 343;
- the end-of-scan pulse and the error flag last one clock;
- the end-of-scan pulse falls inside the readout;
- the amplifier enable tracks the valid flag.

Only the bench's scenarios can show the clock-exact results. These are the 55-clock and 10-clock waits, the absolute clock on which end-of-scan falls in each mode, and the ignoring of the shared start on a chained die. They also include the immunity of a running scan to new starts and to a strap change, and the cycle on which a doubled start is flagged.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESCAN = 2'd1,
        ST_READ    = 2'd2
    } scan_state_t;
endpackage

// File: rtl/scan_start_gate.sv
// Selects the start input this die obeys and flags a start held over two edges.
module scan_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic head_sel,
    input  logic line_start,
    input  logic chain_in,
    output logic start_req,
    output logic start_err
);
    logic held_q;

    assign start_req = head_sel ? line_start : chain_in;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q    <= 1'b0;
            start_err <= 1'b0;
        end else begin
            held_q    <= start_req;
            start_err <= start_req & held_q;
        end
    end
endmodule

// File: rtl/scan_limits.sv
// Terminal counts for the wait and readout phases of the latched scan.
module scan_limits #(
    parameter int HEAD_WAIT  = 55,
    parameter int CHAIN_WAIT = 10,
    parameter int FINE_CLKS  = 344,
    parameter int COARSE_CLKS = 172,
    parameter int EOL_LEAD   = 10,
    parameter int CNTW       = 9
) (
    input  logic            head_q,
    input  logic            fine_q,
    output logic [CNTW-1:0] wait_last,
    output logic [CNTW-1:0] read_last,
    output logic [CNTW-1:0] eol_at
);
    localparam logic [CNTW-1:0] HEAD_LAST   = CNTW'(HEAD_WAIT - 1);
    localparam logic [CNTW-1:0] CHAIN_LAST  = CNTW'(CHAIN_WAIT - 1);
    localparam logic [CNTW-1:0] FINE_LAST   = CNTW'(FINE_CLKS - 1);
    localparam logic [CNTW-1:0] COARSE_LAST = CNTW'(COARSE_CLKS - 1);
    localparam logic [CNTW-1:0] FINE_EOL    = CNTW'(FINE_CLKS - 1 - EOL_LEAD);
    localparam logic [CNTW-1:0] COARSE_EOL  = CNTW'(COARSE_CLKS - 1 - EOL_LEAD);

    always_comb begin
        wait_last = head_q ? HEAD_LAST : CHAIN_LAST;
        read_last = fine_q ? FINE_LAST : COARSE_LAST;
        eol_at    = fine_q ? FINE_EOL  : COARSE_EOL;
    end
endmodule

// File: rtl/scan_fsm.sv
// Idle / wait / readout state machine with a shared phase counter.
module scan_fsm
    import scan_seq_pkg::*;
#(
    parameter int CNTW = 9,
    parameter int IDXW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            head_sel,
    input  logic            fine_res,
    input  logic [CNTW-1:0] wait_last,
    input  logic [CNTW-1:0] read_last,
    input  logic [CNTW-1:0] eol_at,
    output logic            head_q,
    output logic            fine_q,
    output logic [IDXW-1:0] pix_idx,
    output logic            pix_valid,
    output logic            eol_out,
    output logic            amp_on
);
    scan_state_t     state;
    logic [CNTW-1:0] cnt;

    // State register and phase counter
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            head_q <= 1'b0;
            fine_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin          // start
                        state  <= ST_PRESCAN;
                        cnt    <= '0;
                        head_q <= head_sel;
                        fine_q <= fine_res;
                    end
                end
                ST_PRESCAN: begin
                    if (cnt == wait_last) begin   // delay-done
                        state <= ST_READ;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt == read_last) begin   // line-done
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        pix_valid = 1'b0;
        amp_on    = 1'b0;
        eol_out   = 1'b0;
        pix_idx   = '0;
        unique case (state)
            ST_READ: begin
                pix_valid = 1'b1;
                amp_on    = 1'b1;
                eol_out   = (cnt == eol_at);
                pix_idx   = {cnt, 1'b1};
            end
            default: begin
                pix_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int HEAD_WAIT   = 55,
    parameter int CHAIN_WAIT  = 10,
    parameter int FINE_CLKS   = 344,
    parameter int COARSE_CLKS = 172,
    parameter int EOL_LEAD    = 10,
    localparam int CNTW = $clog2(FINE_CLKS > HEAD_WAIT ? FINE_CLKS : HEAD_WAIT),
    localparam int IDXW = CNTW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic            chain_in,
    input  logic            head_sel,
    input  logic            fine_res,
    output logic [IDXW-1:0] pix_idx,
    output logic            pix_valid,
    output logic            eol_out,
    output logic            amp_on,
    output logic            start_err
);
    logic            start_req;
    logic            head_q;
    logic            fine_q;
    logic [CNTW-1:0] wait_last;
    logic [CNTW-1:0] read_last;
    logic [CNTW-1:0] eol_at;

    scan_start_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_sel   (head_sel),
        .line_start (line_start),
        .chain_in   (chain_in),
        .start_req  (start_req),
        .start_err  (start_err)
    );

    scan_limits #(
        .HEAD_WAIT   (HEAD_WAIT),
        .CHAIN_WAIT  (CHAIN_WAIT),
        .FINE_CLKS   (FINE_CLKS),
        .COARSE_CLKS (COARSE_CLKS),
        .EOL_LEAD    (EOL_LEAD),
        .CNTW        (CNTW)
    ) u_limits (
        .head_q    (head_q),
        .fine_q    (fine_q),
        .wait_last (wait_last),
        .read_last (read_last),
        .eol_at    (eol_at)
    );

    scan_fsm #(
        .CNTW (CNTW),
        .IDXW (IDXW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .head_sel  (head_sel),
        .fine_res  (fine_res),
        .wait_last (wait_last),
        .read_last (read_last),
        .eol_at    (eol_at),
        .head_q    (head_q),
        .fine_q    (fine_q),
        .pix_idx   (pix_idx),
        .pix_valid (pix_valid),
        .eol_out   (eol_out),
        .amp_on    (amp_on)
    );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int FINE_CLKS   = 344,
    parameter int COARSE_CLKS = 172,
    parameter int IDXW        = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IDXW-1:0] pix_idx,
    input logic            pix_valid,
    input logic            eol_out,
    input logic            amp_on,
    input logic            start_err
);
    // R3 R4
    first_pair_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> pix_idx == IDXW'(1));

    // R3 R4
    pair_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |-> pix_idx == $past(pix_idx) + IDXW'(2));

    // R11
    last_pair_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(pix_valid) |-> ($past(pix_idx) == IDXW'(2 * FINE_CLKS - 1) ||
                              $past(pix_idx) == IDXW'(2 * COARSE_CLKS - 1)));

    // R5
    eol_width_chk: assert property (@(negedge clk) disable iff (!rst_n)
        eol_out |=> !eol_out);

    // R5
    eol_inside_chk: assert property (@(negedge clk) disable iff (!rst_n)
        eol_out |-> pix_valid);

    // R6
    amp_match_chk: assert property (@(negedge clk) disable iff (!rst_n)
        amp_on == pix_valid);

    // R10
    err_width_chk: assert property (@(negedge clk) disable iff (!rst_n)
        start_err |=> !start_err);
endmodule

bind scan_seq scan_seq_chk #(
    .FINE_CLKS   (FINE_CLKS),
    .COARSE_CLKS (COARSE_CLKS),
    .IDXW        (IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_idx   (pix_idx),
    .pix_valid (pix_valid),
    .eol_out   (eol_out),
    .amp_on    (amp_on),
    .start_err (start_err)
);

// File: tb/tb_scan_seq.sv
module tb_scan_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       chain_in = 1'b0;
    logic       head_sel = 1'b1;
    logic       fine_res = 1'b1;
    logic [9:0] pix_idx;
    logic       pix_valid;
    logic       eol_out;
    logic       amp_on;
    logic       start_err;

    int checks = 0;
    int errors = 0;

    scan_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .chain_in   (chain_in),
        .head_sel   (head_sel),
        .fine_res   (fine_res),
        .pix_idx    (pix_idx),
        .pix_valid  (pix_valid),
        .eol_out    (eol_out),
        .amp_on     (amp_on),
        .start_err  (start_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Starts a scan and checks every clock of it. Inputs change at rising edges;
    // outputs are sampled at rising edges, half a period after the active edge.
    task automatic run_scan(input bit use_chain, input int hold, input int dly,
                            input int act, input int inject_at, input int flip_at,
                            input int err_at, input string tag);
        int last = dly + act;
        @(posedge clk);
        if (use_chain) chain_in = 1'b1; else line_start = 1'b1;
        for (int k = 1; k <= last + 2; k++) begin
            @(posedge clk);
            begin
                bit act_now = (k > dly) && (k <= last);
                int exp_idx = act_now ? 2 * (k - dly - 1) + 1 : 0;
                chk(pix_valid == act_now, tag, "pix_valid", pix_valid, act_now);
                chk(pix_idx == 10'(exp_idx), tag, "pix_idx", pix_idx, exp_idx);
                chk(eol_out == (k == last - 10), tag, "eol_out (R5)", eol_out, k == last - 10);
                chk(amp_on == act_now, tag, "amp_on (R6)", amp_on, act_now);
                chk(start_err == (k == err_at), tag, "start_err (R10)", start_err, k == err_at);
            end
            if (k == hold) begin chain_in = 1'b0; line_start = 1'b0; end
            if (k == inject_at) line_start = 1'b1;
            if (k == inject_at + 1) line_start = 1'b0;
            if (k == flip_at) fine_res = ~fine_res;
        end
    endtask

    task automatic t_reset;
        chk(pix_valid == 1'b0, "R1", "pix_valid in reset", pix_valid, 0);
        @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        chk(pix_valid == 1'b0 && amp_on == 1'b0, "R1", "valid/amp after reset",
            pix_valid + amp_on, 0);
        chk(eol_out == 1'b0 && start_err == 1'b0, "R1", "eol/err after reset",
            eol_out + start_err, 0);
        chk(pix_idx == 10'd0, "R1", "pix_idx after reset", pix_idx, 0);
    endtask

    task automatic t_head_fine;
        head_sel = 1'b1; fine_res = 1'b1;
        run_scan(1'b0, 1, 55, 344, -10, -10, -10, "R2 R3 R11 head fine");
    endtask

    task automatic t_head_coarse;
        head_sel = 1'b1; fine_res = 1'b0;
        run_scan(1'b0, 1, 55, 172, -10, -10, -10, "R2 R4 head coarse");
    endtask

    task automatic t_chain;
        head_sel = 1'b0; fine_res = 1'b1;
        @(posedge clk); line_start = 1'b1;
        @(posedge clk); line_start = 1'b0;
        for (int k = 0; k < 70; k++) begin
            @(posedge clk);
            chk(pix_valid == 1'b0, "R7", "shared start ignored on chained die", pix_valid, 0);
        end
        run_scan(1'b1, 1, 10, 344, -10, -10, -10, "R7 chained fine");
        fine_res = 1'b0;
        run_scan(1'b1, 1, 10, 172, -10, -10, -10, "R7 chained coarse");
    endtask

    task automatic t_busy_and_strap;
        head_sel = 1'b1; fine_res = 1'b0;
        // a restart inside the wait, a strap change, a restart inside readout
        run_scan(1'b0, 1, 55, 172, 20, 30, -10, "R8 R9 busy start in wait");
        fine_res = 1'b0;
        run_scan(1'b0, 1, 55, 172, 100, 60, -10, "R8 R9 busy start in readout");
    endtask

    task automatic t_double;
        head_sel = 1'b1; fine_res = 1'b1;
        run_scan(1'b0, 2, 55, 344, -10, -10, 2, "R10 doubled start");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_head_fine();
        t_head_coarse();
        t_chain();
        t_busy_and_strap();
        t_double();
        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule